// File: doc/BRIEF.md
# BT Message Framing Engine

This block sits between the byte-wide register block of a block-transfer style management interface and the management-controller backend. When the host rings the doorbell, the engine reads the finished request out of the inbound buffer and checks its framing. It answers the interface-capabilities query by itself. Any other request goes to the backend as a byte stream, with a rolling response tag attached. The sequence byte is removed from the stream and kept inside the engine.

When a response with the matching tag comes back, the engine writes it into the outbound buffer as a host-readable frame, with the saved sequence byte put back in. If the response does not fit, the engine writes a short error frame instead. It then loads the frame length and, with the same strobe, tells the register block to drop the controller-busy flag and raise attention towards the host.

Only one request can be in flight at a time. A doorbell that arrives while the engine is busy is lost.

Top module: `bt_frame_engine`

## Requirements
- R1: On a doorbell with a byte count below 4, nothing happens: no length clear, no backend request and no outbound frame.
- R2: Byte 0 of the inbound buffer must equal the byte count minus one, and the count must not exceed IN_DEPTH. Otherwise the engine gives one `inLenClr` pulse and does nothing else: no request and no frame.
- R3: The capabilities query is recognised by inbound byte 1 equal to 0x18 and byte 3 equal to 0x36. It produces a 10-byte frame with no backend traffic: 9, byte1|0x04, the sequence byte (inbound byte 2), 0x36, 0x00, 0x01, min(IN_DEPTH,255), min(OUT_DEPTH,255), 10, 0.
- R4: Every other valid request is sent on the request stream as count−2 beats, in this order: inbound byte 1, then inbound bytes 3 to count−1. `reqLast` is set on the final beat only, and `reqTag` carries the current tag. While `reqValid` is high and `reqReady` is low, the beat stays unchanged.
- R5: A response is accepted only if `rspTag` on its first beat equals the current tag. On acceptance the tag steps by one, modulo 2^TAG_W. A response with any other tag is consumed to its last beat and has no effect.
- R6: An accepted response of N bytes (r0..rN−1), with N ≤ OUT_DEPTH−2, gives the frame N+1, r0, saved sequence, r1..rN−1, with outbound length N+2.
- R7: An accepted response with N > OUT_DEPTH−2 gives the frame 4, r0, saved sequence, r1, 0xCA, with length 5. No write ever addresses beyond OUT_DEPTH−1.
- R8: Each finished frame produces one single-cycle `outLoad` pulse, carrying `outLen`, in a cycle after the last buffer write.
- R9: From a doorbell that starts a request until its frame is loaded, further doorbells are ignored. No request is issued while the engine is waiting for a response.
- R10: After reset, `reqValid`, `rspReady`, `outWrEn`, `outLoad` and `inLenClr` are low and the tag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doorbell | input | 1 | Host signalled that a request is complete |
| inLen | input | LEN_W | Inbound byte count held by the register block |
| inRdAddr | output | log2(IN_DEPTH) | Inbound buffer read address |
| inRdData | input | 8 | Inbound buffer data at `inRdAddr` (same cycle) |
| inLenClr | output | 1 | Pulse: clear the inbound byte count |
| outWrEn | output | 1 | Outbound buffer write strobe |
| outWrAddr | output | log2(OUT_DEPTH) | Outbound buffer write address |
| outWrData | output | 8 | Outbound buffer write data |
| outLoad | output | 1 | Pulse: load `outLen`, clear busy, raise host attention |
| outLen | output | log2(OUT_DEPTH+1) | Outbound frame length |
| reqValid | output | 1 | Request beat valid |
| reqReady | input | 1 | Backend accepts request beat |
| reqData | output | 8 | Request byte |
| reqLast | output | 1 | Final request beat |
| reqTag | output | TAG_W | Current response tag |
| rspValid | input | 1 | Response beat valid |
| rspReady | output | 1 | Engine accepts response beat |
| rspData | input | 8 | Response byte |
| rspLast | input | 1 | Final response beat |
| rspTag | input | TAG_W | Response tag, checked on first beat |

## Verification
The bench builds the engine with IN_DEPTH 16, OUT_DEPTH 12 and TAG_W 2. An outbound depth of 12 means the 10-byte capabilities reply, a response that exactly fills the buffer and an overlong response that would run past its end can all be reached with short streams. A 2-bit tag wraps after four accepted responses, so the modulo step and a mismatched tag are both exercised. A 16-byte inbound depth makes a frame of exactly the depth, and one of the depth plus one, easy to build for the size rule.

// File: rtl/bt_frame_pkg.sv
package bt_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_CHECK, ST_CAP, ST_FWD, ST_WAIT, ST_TAIL, ST_LOAD
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // latch inbound count
    logic idxClr;   // index to 0
    logic idxLd2;   // index to 2 (first forwarded position)
    logic idxInc;   // index step
    logic hdrCap;   // capture header byte at index
    logic capWr;    // write capabilities byte at index
    logic rspBeat;  // response beat taken
    logic tailWr;   // write header/error byte for step at index
    logic tagInc;   // advance response tag
  } ctlT;

  localparam logic [7:0] NETFN_APP_REQ = 8'h18;
  localparam logic [7:0] CMD_CAPS      = 8'h36;
  localparam logic [7:0] CC_TOO_LONG   = 8'hCA;
  localparam logic [7:0] RSP_TIME_SEC  = 8'd10;

endpackage

// File: rtl/bt_frame_data.sv
module bt_frame_data
  import bt_frame_pkg::*;
#(
  parameter int IN_DEPTH  = 64,
  parameter int OUT_DEPTH = 64,
  parameter int TAG_W     = 8,
  parameter int LEN_W     = 8,
  parameter int IN_AW     = $clog2(IN_DEPTH),
  parameter int OUT_AW    = $clog2(OUT_DEPTH),
  parameter int OUT_LW    = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic [LEN_W-1:0]  inLen,
  output logic [IN_AW-1:0]  inRdAddr,
  input  logic [7:0]        inRdData,
  output logic [7:0]        reqData,
  output logic              reqLast,
  output logic [TAG_W-1:0]  reqTag,
  input  logic [7:0]        rspData,
  input  logic              rspLast,
  input  logic [TAG_W-1:0]  rspTag,
  output logic              outWrEn,
  output logic [OUT_AW-1:0] outWrAddr,
  output logic [7:0]        outWrData,
  output logic [OUT_LW-1:0] outLen,
  output logic [LEN_W-1:0]  idx,
  output logic              tooShort,
  output logic              frameOk,
  output logic              isCap,
  output logic              rspHit,
  output logic              overlong
);

  localparam int CNT_W      = $clog2(OUT_DEPTH + 1) + 1;
  localparam int IN_REPORT  = (IN_DEPTH  > 255) ? 255 : IN_DEPTH;
  localparam int OUT_REPORT = (OUT_DEPTH > 255) ? 255 : OUT_DEPTH;

  logic [LEN_W-1:0] frameLen;
  logic [7:0]       lenByte, netfn, seqByte, cmdByte, rspCmd;
  logic [TAG_W-1:0] tag;
  logic [CNT_W-1:0] rspCnt;
  logic             rspFirst, hitReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameLen <= '0; idx <= '0; lenByte <= '0; netfn <= '0;
      seqByte <= '0; cmdByte <= '0; rspCmd <= '0; tag <= '0;
      rspCnt <= '0; rspFirst <= 1'b1; hitReg <= 1'b0;
    end else begin
      if (ctl.start) frameLen <= inLen;
      if (ctl.idxClr)      idx <= '0;
      else if (ctl.idxLd2) idx <= LEN_W'(2);
      else if (ctl.idxInc) idx <= idx + LEN_W'(1);
      if (ctl.hdrCap) begin
        case (idx[1:0])
          2'd0:    lenByte <= inRdData;
          2'd1:    netfn   <= inRdData;
          2'd2:    seqByte <= inRdData;
          default: cmdByte <= inRdData;
        endcase
      end
      if (ctl.rspBeat) begin
        rspFirst <= rspLast;
        if (rspFirst) begin
          hitReg <= (rspTag == tag);
          rspCnt <= CNT_W'(1);
        end else begin
          if (rspCnt == CNT_W'(1)) rspCmd <= rspData;
          if (rspCnt != '1) rspCnt <= rspCnt + CNT_W'(1);
        end
      end
      if (ctl.tagInc) tag <= tag + TAG_W'(1);
    end
  end

  // framing checks
  assign tooShort = inLen < LEN_W'(4);
  assign frameOk  = (frameLen - LEN_W'(1) == LEN_W'(lenByte)) &&
                    ({1'b0, frameLen} <= (LEN_W+1)'(IN_DEPTH));
  assign isCap    = (netfn == NETFN_APP_REQ) && (cmdByte == CMD_CAPS);

  // request stream: the netfn byte takes the place of the sequence byte
  assign inRdAddr = idx[IN_AW-1:0];
  assign reqData  = (idx == LEN_W'(2)) ? netfn : inRdData;
  assign reqLast  = (idx == frameLen - LEN_W'(1));
  assign reqTag   = tag;

  // response tracking
  assign rspHit   = rspFirst ? (rspTag == tag) : hitReg;
  assign overlong = rspCnt > CNT_W'(OUT_DEPTH - 2);
  assign outLen   = isCap    ? OUT_LW'(10) :
                    overlong ? OUT_LW'(5)  : OUT_LW'(rspCnt + CNT_W'(2));

  logic [7:0] capByte;
  always_comb begin
    case (idx[3:0])
      4'd0:    capByte = 8'd9;
      4'd1:    capByte = netfn | 8'h04;
      4'd2:    capByte = seqByte;
      4'd3:    capByte = cmdByte;
      4'd5:    capByte = 8'd1;
      4'd6:    capByte = 8'(IN_REPORT);
      4'd7:    capByte = 8'(OUT_REPORT);
      4'd8:    capByte = RSP_TIME_SEC;
      default: capByte = 8'd0;
    endcase
  end

  logic rspInRange;
  assign rspInRange = rspFirst || (rspCnt < CNT_W'(OUT_DEPTH - 2));

  always_comb begin
    outWrEn   = 1'b0;
    outWrAddr = '0;
    outWrData = '0;
    if (ctl.capWr) begin
      outWrEn   = 1'b1;
      outWrAddr = OUT_AW'(idx);
      outWrData = capByte;
    end else if (ctl.rspBeat && rspHit && rspInRange) begin
      outWrEn   = 1'b1;
      outWrAddr = rspFirst ? OUT_AW'(1) : OUT_AW'(rspCnt + CNT_W'(2));
      outWrData = rspData;
    end else if (ctl.tailWr) begin
      outWrEn = 1'b1;
      case (idx[1:0])
        2'd0: begin outWrAddr = OUT_AW'(2); outWrData = seqByte; end
        2'd1: begin
          outWrAddr = OUT_AW'(0);
          outWrData = overlong ? 8'd4 : 8'(rspCnt + CNT_W'(1));
        end
        2'd2: begin outWrAddr = OUT_AW'(3); outWrData = rspCmd; end
        default: begin outWrAddr = OUT_AW'(4); outWrData = CC_TOO_LONG; end
      endcase
    end
  end

endmodule

// File: rtl/bt_frame_ctrl.sv
module bt_frame_ctrl
  import bt_frame_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             doorbell,
  input  logic [LEN_W-1:0] idx,
  input  logic             tooShort,
  input  logic             frameOk,
  input  logic             isCap,
  input  logic             reqReady,
  input  logic             reqLast,
  input  logic             rspValid,
  input  logic             rspLast,
  input  logic             rspHit,
  input  logic             overlong,
  output ctlT              ctl,
  output logic             reqValid,
  output logic             rspReady,
  output logic             inLenClr,
  output logic             outLoad
);

  stateT st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt      = st;
    ctl      = '0;
    reqValid = 1'b0;
    rspReady = 1'b0;
    inLenClr = 1'b0;
    outLoad  = 1'b0;
    case (st)
      ST_IDLE: if (doorbell && !tooShort) begin
        ctl.start  = 1'b1;
        ctl.idxClr = 1'b1;
        nxt        = ST_HDR;
      end
      ST_HDR: begin
        ctl.hdrCap = 1'b1;
        ctl.idxInc = 1'b1;
        if (idx == LEN_W'(3)) nxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (!frameOk) begin
          inLenClr = 1'b1;
          nxt      = ST_IDLE;
        end else if (isCap) begin
          ctl.idxClr = 1'b1;
          nxt        = ST_CAP;
        end else begin
          ctl.idxLd2 = 1'b1;
          nxt        = ST_FWD;
        end
      end
      ST_CAP: begin
        ctl.capWr  = 1'b1;
        ctl.idxInc = 1'b1;
        if (idx == LEN_W'(9)) nxt = ST_LOAD;
      end
      ST_FWD: begin
        reqValid = 1'b1;
        if (reqReady) begin
          ctl.idxInc = 1'b1;
          if (reqLast) nxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        rspReady = 1'b1;
        if (rspValid) begin
          ctl.rspBeat = 1'b1;
          if (rspLast && rspHit) begin
            ctl.tagInc = 1'b1;
            ctl.idxClr = 1'b1;
            nxt        = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        ctl.tailWr = 1'b1;
        ctl.idxInc = 1'b1;
        if ((idx == LEN_W'(1) && !overlong) || idx == LEN_W'(3)) nxt = ST_LOAD;
      end
      default: begin
        outLoad = 1'b1;
        nxt     = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/bt_frame_engine.sv
module bt_frame_engine
  import bt_frame_pkg::*;
#(
  parameter int IN_DEPTH  = 64,
  parameter int OUT_DEPTH = 64,
  parameter int TAG_W     = 8,
  parameter int LEN_W     = 8,
  localparam int IN_AW    = $clog2(IN_DEPTH),
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int OUT_LW   = $clog2(OUT_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              doorbell,
  input  logic [LEN_W-1:0]  inLen,
  output logic [IN_AW-1:0]  inRdAddr,
  input  logic [7:0]        inRdData,
  output logic              inLenClr,
  output logic              outWrEn,
  output logic [OUT_AW-1:0] outWrAddr,
  output logic [7:0]        outWrData,
  output logic              outLoad,
  output logic [OUT_LW-1:0] outLen,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [7:0]        reqData,
  output logic              reqLast,
  output logic [TAG_W-1:0]  reqTag,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [7:0]        rspData,
  input  logic              rspLast,
  input  logic [TAG_W-1:0]  rspTag
);

  ctlT              ctl;
  logic [LEN_W-1:0] idx;
  logic             tooShort, frameOk, isCap, rspHit, overlong;

  bt_frame_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .doorbell(doorbell), .idx(idx),
    .tooShort(tooShort), .frameOk(frameOk), .isCap(isCap),
    .reqReady(reqReady), .reqLast(reqLast), .rspValid(rspValid),
    .rspLast(rspLast), .rspHit(rspHit), .overlong(overlong),
    .ctl(ctl), .reqValid(reqValid), .rspReady(rspReady),
    .inLenClr(inLenClr), .outLoad(outLoad)
  );

  bt_frame_data #(
    .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .TAG_W(TAG_W), .LEN_W(LEN_W),
    .IN_AW(IN_AW), .OUT_AW(OUT_AW), .OUT_LW(OUT_LW)
  ) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inLen(inLen),
    .inRdAddr(inRdAddr), .inRdData(inRdData),
    .reqData(reqData), .reqLast(reqLast), .reqTag(reqTag),
    .rspData(rspData), .rspLast(rspLast), .rspTag(rspTag),
    .outWrEn(outWrEn), .outWrAddr(outWrAddr), .outWrData(outWrData),
    .outLen(outLen), .idx(idx), .tooShort(tooShort), .frameOk(frameOk),
    .isCap(isCap), .rspHit(rspHit), .overlong(overlong)
  );

endmodule

// File: rtl/bt_frame_chk.sv
module bt_frame_chk #(
  parameter int OUT_DEPTH = 64,
  parameter int TAG_W     = 8,
  parameter int OUT_AW    = 6,
  parameter int OUT_LW    = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [7:0]        reqData,
  input logic              reqLast,
  input logic [TAG_W-1:0]  reqTag,
  input logic              rspReady,
  input logic              outWrEn,
  input logic [OUT_AW-1:0] outWrAddr,
  input logic              outLoad,
  input logic [OUT_LW-1:0] outLen,
  input logic              inLenClr
);

  // R4: a stalled request beat is held
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqData) && $stable(reqLast) && $stable(reqTag));

  // R9: no request while collecting a response
  a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> !reqValid);

  // R5: tag only ever moves by one
  a_r5_tag_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(reqTag) |-> reqTag == TAG_W'($past(reqTag) + 1'b1));

  // R6/R7: loaded length stays inside the outbound buffer
  a_r6_len_range: assert property (@(posedge clk) disable iff (!rstN)
    outLoad |-> (outLen >= OUT_LW'(3)) && ({1'b0, outLen} <= (OUT_LW+1)'(OUT_DEPTH)));

  // R7: writes never leave the buffer
  a_r7_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    outWrEn |-> {1'b0, outWrAddr} < (OUT_AW+1)'(OUT_DEPTH));

  // R2: a dropped frame produces nothing else
  a_r2_drop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    inLenClr |-> !reqValid && !outWrEn && !outLoad);

  // R8: load follows the final write
  a_r8_load_after_write: assert property (@(posedge clk) disable iff (!rstN)
    outLoad |-> !outWrEn && $past(outWrEn));

endmodule

bind bt_frame_engine bt_frame_chk #(
  .OUT_DEPTH(OUT_DEPTH), .TAG_W(TAG_W), .OUT_AW(OUT_AW), .OUT_LW(OUT_LW)
) u_chk (.*);

// File: tb/bt_frame_engine_tb.sv
`timescale 1ns/1ps
module bt_frame_engine_tb;

  localparam int IN_D  = 16;
  localparam int OUT_D = 12;
  localparam int TW    = 2;
  localparam int LW    = 8;

  logic clk = 1'b0, rstN = 1'b0, doorbell = 1'b0;
  logic [LW-1:0] inLen = '0;
  logic [3:0] inRdAddr;
  logic [7:0] inRdData;
  logic inLenClr, outWrEn, outLoad;
  logic [3:0] outWrAddr, outLen;
  logic [7:0] outWrData;
  logic reqValid, reqReady = 1'b0, reqLast;
  logic [7:0] reqData;
  logic [TW-1:0] reqTag;
  logic rspValid = 1'b0, rspReady, rspLast = 1'b0;
  logic [7:0] rspData = '0;
  logic [TW-1:0] rspTag = '0;

  always #5 clk = ~clk;

  bt_frame_engine #(.IN_DEPTH(IN_D), .OUT_DEPTH(OUT_D), .TAG_W(TW), .LEN_W(LW)) u_dut (
    .clk(clk), .rstN(rstN), .doorbell(doorbell), .inLen(inLen),
    .inRdAddr(inRdAddr), .inRdData(inRdData), .inLenClr(inLenClr),
    .outWrEn(outWrEn), .outWrAddr(outWrAddr), .outWrData(outWrData),
    .outLoad(outLoad), .outLen(outLen), .reqValid(reqValid), .reqReady(reqReady),
    .reqData(reqData), .reqLast(reqLast), .reqTag(reqTag), .rspValid(rspValid),
    .rspReady(rspReady), .rspData(rspData), .rspLast(rspLast), .rspTag(rspTag)
  );

  logic [7:0] inBuf [IN_D];
  logic [7:0] outMem [OUT_D];
  assign inRdData = inBuf[inRdAddr];

  int nChecks = 0, nFail = 0, nLoad = 0, nClr = 0, nReqBeat = 0;
  int lastLen = 0;
  logic [7:0] beats [32];
  int beatTagBad, beatLastBad;
  logic [TW-1:0] expTag = '0;

  always @(posedge clk) begin
    if (outWrEn && outWrAddr < OUT_D) outMem[outWrAddr] <= outWrData;
    if (outLoad) begin nLoad++; lastLen = int'(outLen); end
    if (inLenClr) nClr++;
    if (reqValid && reqReady) nReqBeat++;
  end

  // stimulus table: {request byte count, response byte count, sequence byte}
  localparam logic [23:0] VEC [6] = '{
    24'h04_03_11, 24'h06_01_22, 24'h09_0A_33,
    24'h05_0B_44, 24'h10_04_55, 24'h07_14_66
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fillFrame(input int len, input logic [7:0] nfn, input logic [7:0] seq,
                           input logic [7:0] cmd);
    inBuf[0] = 8'(len - 1); inBuf[1] = nfn; inBuf[2] = seq; inBuf[3] = cmd;
    for (int i = 4; i < IN_D; i++) inBuf[i] = 8'(8'hA0 + i + int'(seq));
  endtask

  task automatic ring(input int len);
    @(negedge clk); inLen = LW'(len); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic collect(output int n);
    n = 0; beatTagBad = 0; beatLastBad = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      reqReady = c[0];
      if (reqValid && reqReady) begin
        beats[n] = reqData;
        if (reqTag != expTag) beatTagBad++;
        n++;
        if (reqLast) break;
      end
    end
    @(negedge clk); reqReady = 1'b0;
  endtask

  function automatic logic [7:0] rspByte(input logic [7:0] base, input int k);
    return 8'(int'(base) + 3 * k);
  endfunction

  task automatic sendRsp(input int n, input logic [TW-1:0] tg, input logic [7:0] base);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      rspValid = 1'b1; rspData = rspByte(base, k); rspLast = (k == n - 1); rspTag = tg;
      while (!rspReady) @(negedge clk);
      @(negedge clk);
    end
    rspValid = 1'b0; rspLast = 1'b0;
  endtask

  task automatic waitLoad(input int start, output bit got);
    got = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (nLoad != start) begin got = 1'b1; break; end
    end
  endtask

  task automatic checkRspFrame(input int n, input logic [7:0] seq, input logic [7:0] base,
                               input string req);
    logic [7:0] exp [OUT_D];
    int eLen, bad;
    if (n > OUT_D - 2) begin
      eLen = 5; exp[0] = 8'd4; exp[1] = rspByte(base, 0); exp[2] = seq;
      exp[3] = rspByte(base, 1); exp[4] = 8'hCA;
    end else begin
      eLen = n + 2; exp[0] = 8'(n + 1); exp[1] = rspByte(base, 0); exp[2] = seq;
      for (int k = 1; k < n; k++) exp[k + 2] = rspByte(base, k);
    end
    chk(lastLen == eLen, {req, " length"}, lastLen, eLen);
    bad = 0;
    for (int i = 0; i < eLen; i++) if (outMem[i] !== exp[i]) bad++;
    chk(bad == 0, {req, " frame bytes"}, bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int n, c0, l0, r0, bad;
    bit got;
    for (int i = 0; i < IN_D; i++) inBuf[i] = '0;
    for (int i = 0; i < OUT_D; i++) outMem[i] = 8'hEE;
    idle(5);
    // R10: reset state
    chk(!reqValid && !rspReady && !outWrEn && !outLoad && !inLenClr, "R10 outputs idle",
        {reqValid, rspReady, outWrEn, outLoad, inLenClr}, 0);
    chk(reqTag == 0, "R10 tag zero", reqTag, 0);
    rstN = 1'b1;
    idle(2);

    // R1: short frame ignored
    c0 = nClr; l0 = nLoad; r0 = nReqBeat;
    fillFrame(3, 8'h28, 8'h01, 8'h02); ring(3); idle(20);
    chk(nClr == c0 && nLoad == l0 && nReqBeat == r0, "R1 short frame", nClr + nLoad + nReqBeat,
        c0 + l0 + r0);

    // R2: length byte mismatch
    fillFrame(6, 8'h28, 8'h02, 8'h03); inBuf[0] = 8'd7; ring(6); idle(20);
    chk(nClr == c0 + 1, "R2 mismatch clears length", nClr, c0 + 1);
    chk(nReqBeat == r0 && nLoad == l0, "R2 mismatch no traffic", nReqBeat + nLoad, r0 + l0);
    // R2: count beyond inbound depth
    fillFrame(IN_D + 1, 8'h28, 8'h03, 8'h04); ring(IN_D + 1); idle(20);
    chk(nClr == c0 + 2, "R2 oversize clears length", nClr, c0 + 2);
    chk(nReqBeat == r0 && nLoad == l0, "R2 oversize no traffic", nReqBeat + nLoad, r0 + l0);

    // R3: capabilities query answered locally
    fillFrame(4, 8'h18, 8'h77, 8'h36); ring(4); waitLoad(l0, got);
    chk(got, "R3 capability frame loaded", got, 1);
    chk(lastLen == 10, "R3 capability length", lastLen, 10);
    bad = 0;
    if (outMem[0] != 8'd9)  bad++;
    if (outMem[1] != 8'h1C) bad++;
    if (outMem[2] != 8'h77) bad++;
    if (outMem[3] != 8'h36) bad++;
    if (outMem[4] != 8'd0)  bad++;
    if (outMem[5] != 8'd1)  bad++;
    if (outMem[6] != 8'(IN_D))  bad++;
    if (outMem[7] != 8'(OUT_D)) bad++;
    if (outMem[8] != 8'd10) bad++;
    if (outMem[9] != 8'd0)  bad++;
    chk(bad == 0, "R3 capability bytes", bad, 0);
    chk(nReqBeat == r0, "R3 no backend request", nReqBeat, r0);

    // R5 and R9: wrong tag discarded, doorbell while pending ignored
    fillFrame(5, 8'h30, 8'h5A, 8'h02); ring(5); collect(n);
    chk(n == 3, "R4 beat count", n, 3);
    l0 = nLoad;
    sendRsp(3, expTag + 1'b1, 8'h90); idle(20);
    chk(nLoad == l0, "R5 mismatched tag ignored", nLoad, l0);
    r0 = nReqBeat;
    fillFrame(6, 8'h2C, 8'h01, 8'h03); ring(6); idle(20);
    chk(nReqBeat == r0 && !reqValid, "R9 doorbell while pending", nReqBeat, r0);
    sendRsp(3, expTag, 8'h90); waitLoad(l0, got);
    chk(got, "R5 matching tag accepted", got, 1);
    checkRspFrame(3, 8'h5A, 8'h90, "R6 after discard");
    expTag = expTag + 1'b1;
    idle(3);
    chk(reqTag == expTag, "R5 tag advanced", reqTag, expTag);

    // table walk: R4 forwarding, R6 normal frames, R7 overlong frames, R5 tag wrap
    for (int v = 0; v < 6; v++) begin
      int rq, rs;
      logic [7:0] sq, base;
      rq = int'(VEC[v][23:16]); rs = int'(VEC[v][15:8]); sq = VEC[v][7:0];
      base = 8'(8'h40 + 16 * v);
      fillFrame(rq, 8'h28, sq, 8'(8'h05 + v)); ring(rq); collect(n);
      chk(n == rq - 2, "R4 beat count", n, rq - 2);
      chk(beats[0] == 8'h28, "R4 netfn first", beats[0], 8'h28);
      bad = 0;
      for (int i = 1; i < n; i++) if (beats[i] != inBuf[i + 2]) bad++;
      chk(bad == 0, "R4 payload order", bad, 0);
      chk(beatTagBad == 0, "R5 request tag", beatTagBad, 0);
      l0 = nLoad;
      sendRsp(rs, expTag, base); waitLoad(l0, got);
      chk(got && nLoad == l0 + 1, "R8 one load per frame", nLoad, l0 + 1);
      if (rs > OUT_D - 2) checkRspFrame(rs, sq, base, "R7 overlong");
      else                checkRspFrame(rs, sq, base, "R6 normal");
      expTag = expTag + 1'b1;
    end
    idle(3);
    chk(reqTag == expTag, "R5 tag after wrap", reqTag, expTag);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule